// File: doc/BRIEF.md
# Circular Return-Address Stack

This block keeps the return addresses of a small microcontroller core. The core pushes a 13-bit address when it enters a subroutine or takes an interrupt. It pops when it returns. The address at the top of the stack is always visible on an output, so the program counter logic can load it directly. The stack is held in dedicated registers, separate from program memory and from data memory.

The stack has eight entries. Its pointer is internal and cannot be read or written from outside. The pointer wraps in both directions, and the block never reports an error:

- A ninth push overwrites the oldest entry.
- A pop on an empty stack returns whatever entry the wrapped pointer selects.

A push and a pop in the same cycle replace the top entry and leave the depth unchanged. Reset clears only the pointer. The entries keep whatever they held before reset.

Top module: `ret_stack`

## Requirements
- R1: A push alone writes `data_i` as the new top entry. `top_o` shows that value in the cycle after the push edge.
- R2: A pop alone removes the top entry. From the next cycle `top_o` shows the entry pushed before it (last in, first out).
- R3: Eight pushes in a row are all kept. Seven pops after them return the earlier seven values in reverse order of pushing.
- R4: The pointer wraps modulo 8, so the ninth push overwrites the first entry. After nine pushes p0..p8, pops show p7 down to p1, and the eighth pop shows p8 again.
- R5: A pop with nothing pushed since reset still moves the pointer, from 0 to 7, and `top_o` then shows the contents of entry 6. No error output exists.
- R6: A push and a pop in the same cycle replace the top entry with `data_i` and keep the depth. A later pop therefore shows the entry that was below the replaced one.
- R7: Reset (`rst_ni` low) sets the pointer to zero and leaves every entry unchanged. With the pointer at zero, `top_o` shows entry 7, which is the eighth value of a fill that started from reset.
- R8: In a cycle with neither push nor pop, `top_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the pointer |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| data_i | input | 13 | Address to push |
| top_o | output | 13 | Current top-of-stack entry |

## Verification
A pointer that is off by one, or that wraps at the wrong place, shows up at `top_o` as a value from a neighbouring entry. That happens on the first pop after the fault, and sometimes at once. A wrong write index corrupts an entry silently. That fault appears only when the pointer next reaches the corrupted entry, so the tests fill the stack completely, wrap it, and underflow it. This brings every entry to the output in a known order.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;
  parameter int unsigned STK_DEPTH = 8;
  parameter int unsigned STK_WIDTH = 13;

  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_REPL = 2'b11
  } stk_op_e;
endpackage

// File: rtl/ret_stack_ptr.sv
module ret_stack_ptr
  import ret_stack_pkg::*;
#(
  parameter int unsigned DEPTH = STK_DEPTH,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  stk_op_e          op_i,
  output logic [PTR_W-1:0] sp_o,
  output logic [PTR_W-1:0] wr_idx_o,
  output logic [PTR_W-1:0] top_idx_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] sp_q, sp_inc, sp_dec, sp_d;

  // explicit wrap keeps non-power-of-two depths correct
  assign sp_inc = (sp_q == LAST) ? '0 : sp_q + 1'b1;
  assign sp_dec = (sp_q == '0) ? LAST : sp_q - 1'b1;

  always_comb begin
    sp_d = sp_q;
    unique case (op_i)
      OP_PUSH: sp_d = sp_inc;
      OP_POP:  sp_d = sp_dec;
      default: sp_d = sp_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sp_q <= '0;
    else         sp_q <= sp_d;
  end

  // sp points at the next free slot; the top entry sits one below it
  assign top_idx_o = sp_dec;
  assign wr_idx_o  = (op_i == OP_REPL) ? sp_dec : sp_q;
  assign sp_o      = sp_q;
endmodule

// File: rtl/ret_stack_mem.sv
module ret_stack_mem
  import ret_stack_pkg::*;
#(
  parameter int unsigned DEPTH = STK_DEPTH,
  parameter int unsigned WIDTH = STK_WIDTH,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [PTR_W-1:0] wr_idx_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [PTR_W-1:0] rd_idx_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] ent_q [DEPTH];

  // entries carry no reset
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (we_i && (wr_idx_i == PTR_W'(g))) ent_q[g] <= wdata_i;
    end
  end

  assign rdata_o = ent_q[rd_idx_i];
endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import ret_stack_pkg::*;
#(
  parameter int unsigned DEPTH = STK_DEPTH,
  parameter int unsigned WIDTH = STK_WIDTH,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] top_o
);
  stk_op_e          op;
  logic [PTR_W-1:0] sp, wr_idx, top_idx;
  logic             we;

  assign op = stk_op_e'({pop_i, push_i});
  assign we = push_i;

  ret_stack_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .sp_o      (sp),
    .wr_idx_o  (wr_idx),
    .top_idx_o (top_idx)
  );

  ret_stack_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
    .clk_i    (clk_i),
    .we_i     (we),
    .wr_idx_i (wr_idx),
    .wdata_i  (data_i),
    .rd_idx_i (top_idx),
    .rdata_o  (top_o)
  );
endmodule

// File: rtl/ret_stack_chk.sv
module ret_stack_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 13,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_i,
  input logic             pop_i,
  input logic [WIDTH-1:0] data_i,
  input logic [WIDTH-1:0] top_o,
  input logic [PTR_W-1:0] sp
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  // R1
  push_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> (top_o == $past(data_i)));

  // R6
  replace_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> (top_o == $past(data_i) && sp == $past(sp)));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i) |=> $stable(top_o));

  // R4
  push_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && sp == LAST) |=> (sp == '0));

  // R5
  pop_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && sp == '0) |=> (sp == LAST));

  // R2
  pop_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && sp != '0) |=> (sp == $past(sp) - 1'b1));
endmodule

bind ret_stack ret_stack_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .push_i (push_i),
  .pop_i  (pop_i),
  .data_i (data_i),
  .top_o  (top_o),
  .sp     (sp)
);

// File: tb/ret_stack_bench.sv
`timescale 1ns/1ps
module ret_stack_bench;
  localparam int W = 13;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         push_i = 1'b0;
  logic         pop_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [W-1:0] top_o;

  int n_chk = 0;
  int n_bad = 0;

  ret_stack u_ret_stack (.*);

  always #5 clk_i = ~clk_i;

  task automatic check(input logic [W-1:0] got, input logic [W-1:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s top_o=%h expected=%h", req, got, exp);
    end
  endtask

  // drive at negedge, apply on posedge, sample at next negedge
  task automatic step(input logic pu, input logic po, input logic [W-1:0] d);
    push_i = pu; pop_i = po; data_i = d;
    @(negedge clk_i);
    push_i = 1'b0; pop_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // R1, R7
  task automatic t_reset_ptr();
    do_reset();
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 1'b0, W'(13'h100 + i));
      check(top_o, W'(13'h100 + i), "R1");
    end
    do_reset();
    check(top_o, 13'h107, "R7");
  endtask

  // R2, R3
  task automatic t_lifo();
    do_reset();
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, W'(13'h0A0 + i));
    for (int i = 6; i >= 0; i--) begin
      step(1'b0, 1'b1, '0);
      check(top_o, W'(13'h0A0 + i), (i == 0) ? "R3" : "R2");
    end
  endtask

  // R4
  task automatic t_overwrite();
    do_reset();
    for (int i = 0; i < 9; i++) step(1'b1, 1'b0, W'(13'h1C00 + i));
    check(top_o, 13'h1C08, "R4");
    for (int i = 7; i >= 1; i--) begin
      step(1'b0, 1'b1, '0);
      check(top_o, W'(13'h1C00 + i), "R4");
    end
    step(1'b0, 1'b1, '0);
    check(top_o, 13'h1C08, "R4");
  endtask

  // R5
  task automatic t_underflow();
    do_reset();
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, W'(13'h0330 + i));
    do_reset();
    step(1'b0, 1'b1, '0);
    check(top_o, 13'h0336, "R5");
    step(1'b0, 1'b1, '0);
    check(top_o, 13'h0335, "R5");
  endtask

  // R6
  task automatic t_replace();
    do_reset();
    step(1'b1, 1'b0, 13'h0AAA);
    step(1'b1, 1'b0, 13'h0BBB);
    step(1'b1, 1'b1, 13'h0CCC);
    check(top_o, 13'h0CCC, "R6");
    step(1'b0, 1'b1, '0);
    check(top_o, 13'h0AAA, "R6");
  endtask

  // R8
  task automatic t_hold();
    do_reset();
    step(1'b1, 1'b0, 13'h1234);
    step(1'b1, 1'b0, 13'h0DEF);
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b0, 13'h1FFF);
      check(top_o, 13'h0DEF, "R8");
    end
  endtask

  initial begin
    #(100_000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    t_reset_ptr();
    t_lifo();
    t_overwrite();
    t_underflow();
    t_replace();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule